// File: doc/BRIEF.md
# Instruction Prefetch Queue with Branch Folding

This block keeps the decode stage supplied with instructions by fetching ahead of demand from an instruction memory port and parking the returned words in a small queue. Every word that comes back is predecoded as it arrives. When it is an unconditional jump, the block takes the target from the word, moves the fetch pointer there, and discards whatever was fetched on the sequential path behind it. Decode therefore sees an unbroken stream with the jump folded away. Conditional branches depend on results not yet computed, so they go into the queue like any other instruction, and fetching continues in sequence.

When the pipeline resolves a misprediction or any other change of flow, it asserts the redirect input with a new address. The queue is emptied. Responses still in flight from the old path are recognised and thrown away. Fetching restarts at the new address. The memory port uses a request valid/ready handshake and returns responses in order after any latency of one cycle or more. The decode side uses valid/ready.

Top module: `ifetch_queue`

## Requirements
- R1: While reset is low, `dec_valid` is low. In the first cycle after reset is released, `mem_req_valid` is high and `mem_req_addr` equals `RESET_PC` (default 0).
- R2: Without branches or redirects, request addresses advance by one word per accepted request. Decode receives the words in program order, with none lost and none duplicated.
- R3: A request is issued only when the number of buffered words plus the number of live (non-discarded) outstanding requests is below `DEPTH` (default 4). With decode stalled and a fresh start, exactly `DEPTH` requests are accepted.
- R4: A returned word whose bits [15:11] equal `JMP_OP` (default 5'b11000) is an unconditional jump. The next fetch address is its bits [10:3], and all responses to requests issued before the jump was seen are discarded.
- R5: With `KEEP_NOP` = 0, a folded jump never reaches decode.
- R6: With `KEEP_NOP` = 1, a folded jump reaches decode in its program position as `NOP_WORD` (default 16'h0000).
- R7: Any other opcode, conditional branches included, is delivered unchanged, and fetching continues sequentially after it.
- R8: In a cycle with `redir_valid` high, no request is issued. In the next cycle the queue is empty and `mem_req_addr` equals the redirect address. Responses to requests issued before the redirect are dropped.
- R9: `dec_valid` is low exactly when the queue holds no word, and `dec_instr` shows the oldest word.
- R10: With memory latency of 1 or 2 cycles, memory always ready and decode always ready, `dec_valid` stays high every cycle once the stream is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 8 | Word address of the fetch |
| mem_rsp_valid | input | 1 | Response word valid (in request order) |
| mem_rsp_data | input | 16 | Returned instruction word |
| dec_valid | output | 1 | Queue head is valid |
| dec_ready | input | 1 | Decode takes the head this cycle |
| dec_instr | output | 16 | Instruction at the queue head |
| redir_valid | input | 1 | Flush and restart fetching |
| redir_pc | input | 8 | Restart address |

## Verification
The bench targets in-flight responses that cross a fold or a redirect. A design that miscounts stale responses would hand decode a word from the abandoned path, or would drop a word from the new path. Memory latency, memory backpressure, decode stalls, jump spacing and redirect timing are swept together, so a wrong credit limit shows up either as a lost word after an overflow or as a gap in the stream at low latency. Both fold variants run side by side, which catches a jump that leaks into the queue or a missing no-op marker.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int unsigned OP_W   = 5;
  localparam int unsigned TGT_W  = 8;
  localparam int unsigned REG_W  = 3;
  localparam int unsigned INSN_W = OP_W + TGT_W + REG_W;

  typedef logic [INSN_W-1:0] instr_t;
  typedef logic [TGT_W-1:0]  addr_t;
  typedef logic [OP_W-1:0]   opcode_t;

  typedef struct packed {
    opcode_t          op;
    addr_t            tgt;
    logic [REG_W-1:0] rsel;
  } instr_fields_t;
endpackage

// File: rtl/ifq_predecode.sv
module ifq_predecode
  import ifq_pkg::*;
#(
  parameter opcode_t JMP_OP = 5'b11000
) (
  input  instr_t word,
  output logic   is_jump,
  output addr_t  target
);
  instr_fields_t fld;

  always_comb begin
    fld     = word;
    is_jump = (fld.op == JMP_OP);
    target  = fld.tgt;
  end
endmodule

// File: rtl/ifq_fifo.sv
module ifq_fifo
  import ifq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  instr_t                     push_data,
  input  logic                       pop,
  output logic                       valid,
  output instr_t                     head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0]           wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]           cnt_q, cnt_d;
  logic [DEPTH*INSN_W-1:0] slots_flat;
  logic                    do_pop, ptr_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    instr_t slot_q;
    logic   slot_we;
    assign slot_we = push && !flush && (wptr_q == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q <= push_data;
    end
    assign slots_flat[g*INSN_W +: INSN_W] = slot_q;
  end

  always_comb begin
    do_pop = pop && (cnt_q != '0);
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push)   wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (do_pop) rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      cnt_d = cnt_q + CW'(push) - CW'(do_pop);
    end
    ptr_en = flush || push || do_pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign valid = (cnt_q != '0);
  assign head  = slots_flat[rptr_q*INSN_W +: INSN_W];
  assign count = cnt_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> (cnt_q < CW'(DEPTH)) || do_pop);

  // R9
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !push && !flush && cnt_q == CW'(1)) |=> !valid);
endmodule

// File: rtl/ifq_fetch_ctrl.sv
module ifq_fetch_ctrl
  import ifq_pkg::*;
#(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned OS_MAX   = 8,
  parameter addr_t       RESET_PC = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       redir_valid,
  input  addr_t                      redir_pc,
  input  logic                       req_ready,
  output logic                       req_valid,
  output addr_t                      req_addr,
  input  logic                       rsp_valid,
  input  logic                       rsp_is_jump,
  input  addr_t                      rsp_target,
  input  logic [$clog2(DEPTH+1)-1:0] q_count,
  output logic                       rsp_take
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned OW = $clog2(OS_MAX + 1);
  localparam int unsigned SW = ((OW > CW) ? OW : CW) + 1;

  addr_t         pc_q, pc_d;
  logic [OW-1:0] os_q, os_d, stale_q, stale_d, live_os;
  logic [SW-1:0] occupied;
  logic          req_fire, rsp_drop, fold, pc_en, cnt_en;

  always_comb begin
    live_os   = os_q - stale_q;
    occupied  = SW'(q_count) + SW'(live_os);
    req_valid = !redir_valid && (os_q < OW'(OS_MAX)) && (occupied < SW'(DEPTH));
    req_fire  = req_valid && req_ready;
    rsp_drop  = rsp_valid && (stale_q != '0);
    rsp_take  = rsp_valid && (stale_q == '0) && !redir_valid;
    fold      = rsp_take && rsp_is_jump;

    os_d = os_q + OW'(req_fire) - OW'(rsp_valid);
    if (redir_valid)  stale_d = os_q - OW'(rsp_valid);
    else if (fold)    stale_d = os_d;
    else              stale_d = stale_q - OW'(rsp_drop);

    if (redir_valid)   pc_d = redir_pc;
    else if (fold)     pc_d = rsp_target;
    else if (req_fire) pc_d = pc_q + 1'b1;
    else               pc_d = pc_q;

    pc_en  = redir_valid || fold || req_fire;
    cnt_en = redir_valid || fold || req_fire || rsp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_q    <= '0;
      stale_q <= '0;
    end else if (cnt_en) begin
      os_q    <= os_d;
      stale_q <= stale_d;
    end
  end

  assign req_addr = pc_q;

  // R3
  credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupied <= SW'(DEPTH));

  // R8
  stale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stale_q <= os_q);

  // R8
  redir_pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (req_addr == $past(redir_pc)));

  // R4
  fold_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_is_jump && stale_q == '0 && !redir_valid) |=>
      (req_addr == $past(rsp_target)));
endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue
  import ifq_pkg::*;
#(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned OS_MAX   = 2 * DEPTH,
  parameter opcode_t     JMP_OP   = 5'b11000,
  parameter bit          KEEP_NOP = 1'b0,
  parameter instr_t      NOP_WORD = '0,
  parameter addr_t       RESET_PC = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  output logic   mem_req_valid,
  input  logic   mem_req_ready,
  output addr_t  mem_req_addr,
  input  logic   mem_rsp_valid,
  input  instr_t mem_rsp_data,
  output logic   dec_valid,
  input  logic   dec_ready,
  output instr_t dec_instr,
  input  logic   redir_valid,
  input  addr_t  redir_pc
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          is_jump, rsp_take, push;
  addr_t         jmp_target;
  instr_t        push_data;
  logic [CW-1:0] q_count;

  ifq_predecode #(.JMP_OP(JMP_OP)) u_predecode (
    .word    (mem_rsp_data),
    .is_jump (is_jump),
    .target  (jmp_target)
  );

  ifq_fetch_ctrl #(
    .DEPTH    (DEPTH),
    .OS_MAX   (OS_MAX),
    .RESET_PC (RESET_PC)
  ) u_fetch_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .req_ready   (mem_req_ready),
    .req_valid   (mem_req_valid),
    .req_addr    (mem_req_addr),
    .rsp_valid   (mem_rsp_valid),
    .rsp_is_jump (is_jump),
    .rsp_target  (jmp_target),
    .q_count     (q_count),
    .rsp_take    (rsp_take)
  );

  if (KEEP_NOP) begin : g_keep_marker
    assign push      = rsp_take;
    assign push_data = is_jump ? NOP_WORD : mem_rsp_data;
  end else begin : g_drop_jump
    assign push      = rsp_take && !is_jump;
    assign push_data = mem_rsp_data;
  end

  ifq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (redir_valid),
    .push      (push),
    .push_data (push_data),
    .pop       (dec_ready),
    .valid     (dec_valid),
    .head      (dec_instr),
    .count     (q_count)
  );

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !dec_valid);

  // R8
  no_req_on_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !(mem_req_valid && mem_req_ready && $past(redir_valid)));
endmodule

// File: tb/ifetch_queue_bench.sv
module ifetch_queue_bench;
  import ifq_pkg::*;

  localparam opcode_t JOP  = 5'b11000;
  localparam opcode_t COP  = 5'b11001;
  localparam opcode_t AOP  = 5'b00001;
  localparam instr_t  NOPW = 16'h0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redir_valid = 1'b0;
  addr_t       redir_pc = '0;
  logic [1:0]  dec_ready = '0, mreq_ready = '0, mrsp_valid = '0;
  logic [1:0]  mreq_valid, dvalid;
  addr_t       mreq_addr [2];
  instr_t      mrsp_data [2];
  instr_t      dinstr [2];

  instr_t prog [256];
  addr_t  wpc [2];
  logic   pv [2][4];
  addr_t  pa [2][4];
  int     lat = 1, dr_pat = 0, cyc = 0, tests = 0, fails = 0;
  bit     mr_pat = 1'b0, rst_next = 1'b0;
  int     pops [2], fires [2], lowv [2];

  always #10 clk = ~clk;

  ifetch_queue #(.DEPTH(4), .JMP_OP(JOP), .KEEP_NOP(1'b0)) u_ifetch_queue (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mreq_valid[0]), .mem_req_ready(mreq_ready[0]), .mem_req_addr(mreq_addr[0]),
    .mem_rsp_valid(mrsp_valid[0]), .mem_rsp_data(mrsp_data[0]),
    .dec_valid(dvalid[0]), .dec_ready(dec_ready[0]), .dec_instr(dinstr[0]),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  ifetch_queue #(.DEPTH(4), .JMP_OP(JOP), .KEEP_NOP(1'b1), .NOP_WORD(NOPW)) u_ifetch_queue_nop (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mreq_valid[1]), .mem_req_ready(mreq_ready[1]), .mem_req_addr(mreq_addr[1]),
    .mem_rsp_valid(mrsp_valid[1]), .mem_rsp_data(mrsp_data[1]),
    .dec_valid(dvalid[1]), .dec_ready(dec_ready[1]), .dec_instr(dinstr[1]),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic instr_t next_exp(input int i);
    instr_t w;
    for (int n = 0; n < 300; n++) begin
      w = prog[wpc[i]];
      if (w[15:11] == JOP) begin
        wpc[i] = w[10:3];
        if (i == 1) return NOPW;
      end else begin
        wpc[i] = wpc[i] + 1'b1;
        return w;
      end
    end
    return 16'hDEAD;
  endfunction

  task automatic load_prog(input int period, input int skip);
    for (int a = 0; a < 256; a++) begin
      if (period > 0 && (a % period) == period - 1)
        prog[a] = {JOP, 8'((a + skip) % 256), 3'b000};
      else if ((a % 7) == 3)
        prog[a] = {COP, 8'(a) ^ 8'h55, 3'b010};
      else
        prog[a] = {AOP, 8'(a), 3'(a)};
    end
  endtask

  task automatic tick(input bit rd, input addr_t rp, input bit track);
    instr_t e;
    @(negedge clk);
    cyc++;
    rst_n       = rst_next;
    redir_valid = rd;
    redir_pc    = rp;
    for (int i = 0; i < 2; i++) begin
      dec_ready[i]  = (dr_pat == 0) ? 1'b1 : (dr_pat == 1) ? 1'b0 : ((cyc % dr_pat) != 0);
      mreq_ready[i] = mr_pat ? ((cyc % 3) != 1) : 1'b1;
      mrsp_valid[i] = pv[i][0];
      mrsp_data[i]  = prog[pa[i][0]];
      for (int k = 0; k < 3; k++) begin
        pv[i][k] = pv[i][k+1];
        pa[i][k] = pa[i][k+1];
      end
      pv[i][3] = 1'b0;
    end
    #1;
    for (int i = 0; i < 2; i++) begin
      if (rst_n && mreq_valid[i] && mreq_ready[i]) begin
        pv[i][lat-1] = 1'b1;
        pa[i][lat-1] = mreq_addr[i];
        fires[i]++;
      end
      if (!dvalid[i]) lowv[i]++;
      if (rd) begin
        wpc[i] = rp;
      end else if (track && rst_n && dvalid[i] && dec_ready[i]) begin
        e = next_exp(i);
        if (i == 0) check(dinstr[i] == e, "R2 R4 R5 R7 stream", int'(dinstr[i]), int'(e));
        else        check(dinstr[i] == e, "R2 R4 R6 R7 stream", int'(dinstr[i]), int'(e));
        pops[i]++;
      end
    end
  endtask

  task automatic do_reset();
    rst_next = 1'b0;
    for (int i = 0; i < 2; i++) begin
      wpc[i] = '0; pops[i] = 0; fires[i] = 0; lowv[i] = 0;
      for (int k = 0; k < 4; k++) begin pv[i][k] = 1'b0; pa[i][k] = '0; end
    end
    repeat (3) tick(1'b0, '0, 1'b0);
    for (int i = 0; i < 2; i++) check(dvalid[i] == 1'b0, "R1 valid low in reset", dvalid[i], 0);
    rst_next = 1'b1;
    tick(1'b0, '0, 1'b1);
    for (int i = 0; i < 2; i++) begin
      check(mreq_valid[i] == 1'b1, "R1 first request valid", mreq_valid[i], 1);
      check(mreq_addr[i] == 8'h00, "R1 first request address", mreq_addr[i], 0);
      check(dvalid[i] == 1'b0, "R9 empty after reset", dvalid[i], 0);
    end
  endtask

  task automatic run_cfg(input int l, input bit mrp, input int drp, input int period,
                         input int skip, input int ncyc, input int rev);
    bit    was_rd = 1'b0;
    addr_t last_rp = '0;
    bit    rd;
    addr_t rp;
    lat = l; mr_pat = mrp; dr_pat = drp;
    load_prog(period, skip);
    do_reset();
    for (int c = 0; c < ncyc; c++) begin
      rd = (rev > 0) && ((c % rev) == rev - 1);
      rp = 8'((c * 13 + 5) % 256);
      tick(rd, rp, 1'b1);
      if (was_rd) begin
        for (int i = 0; i < 2; i++) begin
          check(dvalid[i] == 1'b0, "R8 queue empty after redirect", dvalid[i], 0);
          check(mreq_addr[i] == last_rp, "R8 fetch restarts at redirect", mreq_addr[i], last_rp);
        end
      end
      was_rd = rd;
      last_rp = rp;
    end
    for (int i = 0; i < 2; i++) check(pops[i] > 0, "R2 stream progresses", pops[i], 1);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R10: throughput with short latency, no branches
    for (int l = 1; l <= 2; l++) begin
      lat = l; mr_pat = 1'b0; dr_pat = 0;
      load_prog(0, 0);
      do_reset();
      repeat (8) tick(1'b0, '0, 1'b1);
      lowv[0] = 0; lowv[1] = 0;
      repeat (40) tick(1'b0, '0, 1'b1);
      for (int i = 0; i < 2; i++) check(lowv[i] == 0, "R10 no bubbles", lowv[i], 0);
    end

    // R3: decode stalled, request count stops at the queue depth
    lat = 2; mr_pat = 1'b0; dr_pat = 1;
    load_prog(0, 0);
    do_reset();
    repeat (20) tick(1'b0, '0, 1'b1);
    for (int i = 0; i < 2; i++) begin
      check(fires[i] == 4, "R3 requests limited to depth", fires[i], 4);
      check(dvalid[i] == 1'b1, "R9 valid with words buffered", dvalid[i], 1);
    end
    dr_pat = 0;
    repeat (30) tick(1'b0, '0, 1'b1);
    for (int i = 0; i < 2; i++) check(pops[i] >= 20, "R3 R2 drain after stall", pops[i], 20);

    // R4 R5 R6 R7 R8: sweep latency, backpressure, decode pattern, jump spacing, redirects
    for (int l = 1; l <= 4; l++)
      for (int m = 0; m < 2; m++)
        for (int d = 0; d < 3; d++)
          for (int p = 0; p < 2; p++)
            run_cfg(l, m[0], (d == 0) ? 0 : (d == 1) ? 3 : 5,
                    (p == 0) ? 3 : 5, (p == 0) ? 17 : 42, 160, (d == 2) ? 0 : 37);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule